// File: doc/BRIEF.md
# JTAG Loopback Self-Test Buffer

This block lets a debug adapter check its own wiring when no JTAG target is attached. The host-side USB bridge writes one byte to the block. The block treats the two nibbles of that byte as copies of one 4-bit pattern. When the copies agree, it places the pattern on four JTAG header pins. An external cable links each of those pins to a neighbouring header pin, and the block samples the four neighbours. It then returns what it sensed to the host as a byte in which the same nibble appears twice.

The host passes the test by writing 0xAA and then 0x55 and reading each byte back unchanged. A host line that is stuck or shorted makes the two nibbles of the written byte differ. In that case the block keeps the header quiet and answers 0x00. A short between header pins changes the sensed nibble, so the byte read back no longer matches the byte that was written.

The sensed pins, together with the nibble-disagreement flag, pass through a synchronizer whose depth is a parameter (2 by default, 0 for a purely combinational path). With the default depth, the return byte reflects the inputs as they were two clock edges earlier.

Top module: `jtag_loopback_selftest`

## Requirements
- R1: When host_byte_i[7:4] equals host_byte_i[3:0], hdr_drive_o equals host_byte_i[3:0] in the same cycle. Bit 0 drives TRST, bit 1 drives TDI, bit 2 drives RTCK and bit 3 drives nSRST.
- R2: When the two host nibbles differ, hdr_drive_o is 4'b0000.
- R3: With agreeing nibbles, host_ret_o equals {s, s}, where s is hdr_sense_i as it was two clock edges earlier (bit 0 TMS, bit 1 TCK, bit 2 TDO, bit 3 DBGRQ). One edge after a change, host_ret_o still shows the old value.
- R4: When the host nibbles sampled two edges earlier differed, host_ret_o is 8'h00 whatever hdr_sense_i holds.
- R5: With each driven pin looped straight to its paired sensed pin, host byte 0xAA returns 0xAA and host byte 0x55 returns 0x55.
- R6: If two looped pins are shorted as a wired-AND, host byte 0xAA returns a byte other than 0xAA.
- R7: While rst is high, and on the first cycle after it falls, host_ret_o is 8'h00.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the sensed pins |
| rst | input | 1 | Synchronous active-high reset |
| host_byte_i | input | 8 | Test byte from the host bridge |
| hdr_drive_o | output | 4 | Driven header pins {nSRST, RTCK, TDI, TRST} |
| hdr_sense_i | input | 4 | Sensed header pins {DBGRQ, TDO, TCK, TMS} |
| host_ret_o | output | 8 | Return byte to the host bridge |

## Verification
The latency properties assume that the host byte and the sensed pins are sampled only at clock edges. They also assume that the pins have been sampled on two consecutive edges outside reset before the checked edge. The bench changes every input just after a falling edge and holds it for at least two rising edges before it reads a result. Its loopback model derives the sensed nibble from the driven nibble without a delay. This keeps every sample within the settled window that the properties describe.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int unsigned LB_NIB_W  = 4;
    localparam int unsigned LB_BYTE_W = 2 * LB_NIB_W;

    typedef logic [LB_NIB_W-1:0]  lb_nib_t;
    typedef logic [LB_BYTE_W-1:0] lb_byte_t;

    // One synchronized sample: sensed pins plus the nibble-disagreement flag
    typedef struct packed {
        logic    fault;
        lb_nib_t pins;
    } lb_sample_t;

    function automatic lb_nib_t lb_hi(input lb_byte_t b);
        return b[LB_BYTE_W-1:LB_NIB_W];
    endfunction

    function automatic lb_nib_t lb_lo(input lb_byte_t b);
        return b[LB_NIB_W-1:0];
    endfunction

    function automatic lb_byte_t lb_dup(input lb_nib_t n);
        return {n, n};
    endfunction
endpackage

// File: rtl/lb_pattern_check.sv
module lb_pattern_check
    import lb_pkg::*;
(
    input  lb_byte_t host_byte,
    output lb_nib_t  drive,
    output logic     fault
);
    always_comb begin
        fault = (lb_hi(host_byte) != lb_lo(host_byte));
        drive = fault ? '0 : lb_lo(host_byte);
    end
endmodule

// File: rtl/lb_sense_sync.sv
module lb_sense_sync
    import lb_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  lb_sample_t d,
    output lb_sample_t q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            lb_sample_t stage_q [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lb_return_pack.sv
module lb_return_pack
    import lb_pkg::*;
(
    input  lb_sample_t smp,
    output lb_byte_t   ret
);
    always_comb begin
        ret = smp.fault ? '0 : lb_dup(smp.pins);
    end
endmodule

// File: rtl/jtag_loopback_selftest.sv
module jtag_loopback_selftest
    import lb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] host_byte_i,
    output logic [3:0] hdr_drive_o,
    input  logic [3:0] hdr_sense_i,
    output logic [7:0] host_ret_o
);
    logic       nib_fault;
    lb_sample_t raw_smp;
    lb_sample_t sync_smp;

    lb_pattern_check u_check (
        .host_byte (host_byte_i),
        .drive     (hdr_drive_o),
        .fault     (nib_fault)
    );

    assign raw_smp.fault = nib_fault;
    assign raw_smp.pins  = hdr_sense_i;

    lb_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_smp),
        .q   (sync_smp)
    );

    lb_return_pack u_pack (
        .smp (sync_smp),
        .ret (host_ret_o)
    );

    // Header-side checks
    AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (host_byte_i[7:4] == host_byte_i[3:0]) |-> (hdr_drive_o == host_byte_i[3:0])); // R1
    AST_DRIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (host_byte_i[7:4] != host_byte_i[3:0]) |-> (hdr_drive_o == 4'h0)); // R2
    AST_RET_TWIN: assert property (@(posedge clk) disable iff (rst)
        host_ret_o[7:4] == host_ret_o[3:0]); // R3
    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (host_ret_o == 8'h00)); // R7

    // Latency checks for the default two-stage path
    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            logic [1:0] live_edges;
            always_ff @(posedge clk) begin
                if (rst) live_edges <= '0;
                else if (live_edges != 2'd3) live_edges <= live_edges + 2'd1;
            end
            AST_RET_LATENCY: assert property (@(posedge clk) disable iff (rst)
                (live_edges >= 2'd2 && $past(host_byte_i[7:4], 2) == $past(host_byte_i[3:0], 2))
                |-> (host_ret_o == {$past(hdr_sense_i, 2), $past(hdr_sense_i, 2)})); // R3
            AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
                (live_edges >= 2'd2 && $past(host_byte_i[7:4], 2) != $past(host_byte_i[3:0], 2))
                |-> (host_ret_o == 8'h00)); // R4
        end
    endgenerate
endmodule

// File: tb/test_jtag_loopback_selftest.sv
module test_jtag_loopback_selftest;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_byte = 8'h00;
    logic [3:0] drive;
    logic [3:0] sense;
    logic [7:0] ret;
    int         mode = 0;   // 0 straight loop, 1 short pins 0/1 (wired-AND), 2 sense forced 4'hF
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    always_comb begin
        case (mode)
            1:       sense = {drive[3:2], drive[1] & drive[0], drive[1] & drive[0]};
            2:       sense = 4'hF;
            default: sense = drive;
        endcase
    end

    jtag_loopback_selftest i_jtag_loopback_selftest (
        .clk         (clk),
        .rst         (rst),
        .host_byte_i (host_byte),
        .hdr_drive_o (drive),
        .hdr_sense_i (sense),
        .host_ret_o  (ret)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] b);
        @(negedge clk);
        host_byte = b;
        #1;
    endtask

    task automatic settle();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        host_byte = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 during reset", ret, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 first cycle after reset", ret, 8'h00);

        // Full sweep, straight loopback: R1, R2, R3, R4
        for (int b = 0; b < 256; b++) begin
            logic [3:0] hi, lo;
            hi = b[7:4];
            lo = b[3:0];
            apply(b[7:0]);
            chk(hi == lo ? "R1 drive" : "R2 drive quiet", {4'h0, drive}, {4'h0, (hi == lo) ? lo : 4'h0});
            settle();
            chk(hi == lo ? "R3 return" : "R4 return zero", ret, (hi == lo) ? {lo, lo} : 8'h00);
        end

        // R3 latency: old value survives one edge
        apply(8'h33);
        settle();
        apply(8'hCC);
        @(posedge clk);
        @(negedge clk);
        chk("R3 one edge old", ret, 8'h33);
        @(posedge clk);
        @(negedge clk);
        chk("R3 two edges new", ret, 8'hCC);

        // R5: healthy patterns
        apply(8'hAA); settle(); chk("R5 AA", ret, 8'hAA);
        apply(8'h55); settle(); chk("R5 55", ret, 8'h55);

        // R6: wired-AND short between pins 0 and 1
        mode = 1;
        apply(8'hAA); settle();
        n_checks++;
        if (ret == 8'hAA) begin
            n_errors++;
            $display("FAIL R6 short: actual=%02h expected=not AA", ret);
        end
        chk("R6 short value", ret, 8'h88);

        // R4: stuck host line, sense pins all high must not leak
        mode = 2;
        apply(8'hAB); settle();
        chk("R4 stuck line", ret, 8'h00);
        chk("R2 stuck line drive", {4'h0, drive}, 8'h00);
        apply(8'h00); settle();
        chk("R3 sense forced", ret, 8'hFF);

        // R7: mid-run reset clears output
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid-run reset", ret, 8'h00);
        rst = 1'b0;
        mode = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule